// File: doc/BRIEF.md
# Microsecond Countdown Timer Channel

A single timer channel that counts down once for each pulse of an external 1 µs tick enable. Software writes one control word, which carries an enable flag, a periodic flag and a preset count. That one write arms the channel, selects the mode and loads the counter. When the count passes below zero, the channel raises a level-high interrupt. In periodic mode the counter reloads the preset and keeps running. In one-shot mode the channel disarms itself and the counter stays at zero.

Software acknowledges the interrupt by writing a dedicated bit in a second register, the status/clear register. Reading the status register has no side effect. The same status register returns the pending flag and the live count, so software can see how far the channel has run. Because software loads ticks minus one, a preset of N reaches expiry on tick N+1.

Top module: `us_countdown_timer`

## Requirements
- R1: Select 0 is the control register. Bit 31 is enable, bit 30 is periodic and bits 28:0 are the preset. Reading select 0 returns these fields, with bit 29 read as 0.
- R2: Select 1 is the status register. It reads the pending interrupt in bit 30 and the current count in bits 28:0. All other bits read as 0.
- R3: A control write loads the counter with the new preset in the same cycle, even when the channel is already running. After that, the count drops by exactly one on each cycle where the tick is high and the channel is enabled, and it holds on every other cycle.
- R4: With preset N, the interrupt rises on the (N+1)th tick after the write. A preset of 0 expires on the first tick. The largest preset, 0x1FFFFFFF, loads in full and counts down normally.
- R5: In one-shot mode (bit 30 = 0), expiry clears the enable flag and the count stays at 0 until the next control write.
- R6: In periodic mode (bit 30 = 1), expiry reloads the preset and counting continues. With a preset of 9999, the interrupt rises every 10000 ticks.
- R7: A control write of all zeros stops the counter, and no interrupt follows from further ticks.
- R8: The interrupt is an active-high level. It is set on expiry and holds until a status-register write has bit 30 set. A status write with bit 30 clear has no effect.
- R9: If an expiry and a clearing write fall in the same cycle, the interrupt stays asserted.
- R10: After reset, the control register, the count and the interrupt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs tick enable from the shared timebase |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status/clear |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control, 1 status |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt, active-high level |

## Verification
The bench builds the channel with its default 29-bit count and drives the tick input itself, one pulse per clock. This makes a full 10000-tick periodic interval cheap, so two consecutive periodic expiries are observed. It also lets the maximum preset be loaded and decremented. Short presets cover the tick-exact expiry points. Directed cases cover an expiry and a clear landing in the same cycle, and a restart in the middle of a count.

// File: rtl/us_countdown_timer_pkg.sv
`timescale 1ns/1ps
package us_countdown_timer_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned MODE_BIT = 30;
  localparam int unsigned PEND_BIT = 30;
  localparam int unsigned CLR_BIT  = 30;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/us_countdown_timer_regif.sv
`timescale 1ns/1ps
module us_countdown_timer_regif
  import us_countdown_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 29
) (
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  input  logic              en_i,
  input  tmr_mode_e         mode_i,
  input  logic [CNT_W-1:0]  preset_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              pend_i,
  output logic              ld_o,
  output logic              ld_en_o,
  output tmr_mode_e         ld_mode_o,
  output logic [CNT_W-1:0]  ld_preset_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  reg_sel_e wsel, rsel;
  assign wsel = reg_sel_e'(wr_sel_i);
  assign rsel = reg_sel_e'(rd_sel_i);

  assign ld_o        = wr_en_i && (wsel == SEL_CTRL);
  assign ld_en_o     = wr_data_i[EN_BIT];
  assign ld_mode_o   = tmr_mode_e'(wr_data_i[MODE_BIT]);
  assign ld_preset_o = wr_data_i[CNT_W-1:0];
  assign clr_o       = wr_en_i && (wsel == SEL_STAT) && wr_data_i[CLR_BIT];

  always_comb begin
    rd_data_o = '0;
    unique case (rsel)
      SEL_CTRL: begin
        rd_data_o = {{PAD_W{1'b0}}, preset_i};
        rd_data_o[EN_BIT]   = en_i;
        rd_data_o[MODE_BIT] = (mode_i == MODE_PERIODIC);
      end
      SEL_STAT: begin
        rd_data_o = {{PAD_W{1'b0}}, count_i};
        rd_data_o[PEND_BIT] = pend_i;
      end
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/us_countdown_timer_core.sv
`timescale 1ns/1ps
module us_countdown_timer_core
  import us_countdown_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic             ld_en_i,
  input  tmr_mode_e        ld_mode_i,
  input  logic [CNT_W-1:0] ld_preset_i,
  output logic             en_o,
  output tmr_mode_e        mode_o,
  output logic [CNT_W-1:0] preset_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic             en_q;
  tmr_mode_e        mode_q;
  logic [CNT_W-1:0] preset_q, count_q;
  logic             at_zero, step;

  assign at_zero  = (count_q == '0);
  assign step     = en_q && tick_i && !ld_i;   // a write wins over a tick
  assign expire_o = step && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      mode_q   <= MODE_ONESHOT;
      preset_q <= '0;
      count_q  <= '0;
    end else if (ld_i) begin
      en_q     <= ld_en_i;
      mode_q   <= ld_mode_i;
      preset_q <= ld_preset_i;
      count_q  <= ld_preset_i;
    end else if (step) begin
      if (!at_zero) begin
        count_q <= count_q - 1'b1;
      end else if (mode_q == MODE_PERIODIC) begin
        count_q <= preset_q;
      end else begin
        en_q <= 1'b0;   // one-shot: disarm, count rests at zero
      end
    end
  end

  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign preset_o = preset_q;
  assign count_o  = count_q;
endmodule

// File: rtl/us_countdown_timer_irq.sv
`timescale 1ns/1ps
module us_countdown_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;   // set beats clear
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/us_countdown_timer.sv
`timescale 1ns/1ps
module us_countdown_timer
  import us_countdown_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 29
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  logic             ctrl_ld, ld_en, clr_req, expire, en_q;
  tmr_mode_e        ld_mode, mode_q;
  logic [CNT_W-1:0] ld_preset, preset_q, count_q;

  initial begin
    if (CNT_W < 1 || CNT_W > 29) $error("CNT_W must be 1..29");
  end

  us_countdown_timer_regif #(.CNT_W(CNT_W)) u_regif (
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .rd_sel_i   (rd_sel_i),
    .en_i       (en_q),
    .mode_i     (mode_q),
    .preset_i   (preset_q),
    .count_i    (count_q),
    .pend_i     (irq_o),
    .ld_o       (ctrl_ld),
    .ld_en_o    (ld_en),
    .ld_mode_o  (ld_mode),
    .ld_preset_o(ld_preset),
    .clr_o      (clr_req),
    .rd_data_o  (rd_data_o)
  );

  us_countdown_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .ld_i       (ctrl_ld),
    .ld_en_i    (ld_en),
    .ld_mode_i  (ld_mode),
    .ld_preset_i(ld_preset),
    .en_o       (en_q),
    .mode_o     (mode_q),
    .preset_o   (preset_q),
    .count_o    (count_q),
    .expire_o   (expire)
  );

  us_countdown_timer_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (expire),
    .clr_i (clr_req),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/us_countdown_timer_chk.sv
`timescale 1ns/1ps
module us_countdown_timer_chk #(
  parameter int unsigned CNT_W = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             ld_i,
  input logic             clr_i,
  input logic             expire_i,
  input logic             en_i,
  input logic             per_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [CNT_W-1:0] count_i,
  input logic             irq_i
);
  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_i) |=> $stable(count_i));

  assert_count_le_preset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= preset_i);

  assert_oneshot_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !per_i) |=> (!en_i && count_i == '0));

  assert_periodic_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && per_i) |=> (en_i && count_i == $past(preset_i)));

  assert_irq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> irq_i);

  assert_irq_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !irq_i);

  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !clr_i) |=> irq_i);

  assert_expire_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && expire_i) |=> irq_i);
endmodule

bind us_countdown_timer us_countdown_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .ld_i    (ctrl_ld),
  .clr_i   (clr_req),
  .expire_i(expire),
  .en_i    (en_q),
  .per_i   (mode_q == us_countdown_timer_pkg::MODE_PERIODIC),
  .preset_i(preset_q),
  .count_i (count_q),
  .irq_i   (irq_o)
);

// File: tb/us_countdown_timer_tb.sv
`timescale 1ns/1ps
module us_countdown_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_sel_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  us_countdown_timer u_dut (.*);

  // vector table: clear irq, write control, apply ticks, then check
  localparam int NV = 7;
  localparam logic [31:0] V_CTRL [NV] = '{32'h8000_0005, 32'h8000_0005, 32'h8000_0000,
                                          32'hC000_0003, 32'hC000_0003, 32'h0000_0000,
                                          32'h8000_0007};
  localparam int          V_TCK  [NV] = '{3, 6, 1, 4, 6, 5, 0};
  localparam logic [31:0] V_CNT  [NV] = '{32'd2, 32'd0, 32'd0, 32'd3, 32'd1, 32'd0, 32'd7};
  localparam logic        V_IRQ  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] V_RB   [NV] = '{32'h8000_0005, 32'h0000_0005, 32'h0000_0000,
                                          32'hC000_0003, 32'hC000_0003, 32'h0000_0000,
                                          32'h8000_0007};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    rd_sel_i = sel;
    #1 d = rd_data_o;
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    rd(1'b0, r); check("R10 ctrl after reset", r, 32'h0);
    rd(1'b1, r); check("R10 status after reset", r, 32'h0);
    check("R10 irq after reset", {31'b0, irq_o}, 32'h0);
    ticks(3);
    rd(1'b1, r); check("R3 idle ticks hold count", r, 32'h0);

    // R1 R2 R4 R5 R6 R7 vector walk
    for (int v = 0; v < NV; v++) begin
      wr(1'b1, 32'h4000_0000);
      wr(1'b0, V_CTRL[v]);
      ticks(V_TCK[v]);
      rd(1'b1, r);
      check($sformatf("R2/R4/R6 vec%0d count", v), {3'b0, r[28:0]}, V_CNT[v]);
      check($sformatf("R8/R7 vec%0d irq", v), {31'b0, irq_o}, {31'b0, V_IRQ[v]});
      check($sformatf("R2 vec%0d status pending bit", v), {31'b0, r[30]}, {31'b0, V_IRQ[v]});
      rd(1'b0, r);
      check($sformatf("R1/R5 vec%0d ctrl readback", v), r, V_RB[v]);
    end

    // R5 one-shot holds at zero after expiry
    wr(1'b1, 32'h4000_0000);
    wr(1'b0, 32'h8000_0001);
    ticks(2);
    check("R4 preset 1 expires on tick 2", {31'b0, irq_o}, 32'h1);
    ticks(4);
    rd(1'b1, r); check("R5 one-shot stays at zero", r, 32'h4000_0000);

    // R8 clear with bit 30 low is ignored, with bit 30 high clears
    wr(1'b1, 32'hBFFF_FFFF);
    check("R8 clear without bit30 ignored", {31'b0, irq_o}, 32'h1);
    wr(1'b1, 32'h4000_0000);
    check("R8 clear with bit30", {31'b0, irq_o}, 32'h0);
    rd(1'b0, r); check("R8 status write leaves ctrl", r, 32'h0000_0001);

    // R9 expiry and clear in the same cycle
    wr(1'b0, 32'h8000_0000);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 32'h4000_0000;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    check("R9 expiry beats clear", {31'b0, irq_o}, 32'h1);
    wr(1'b1, 32'h4000_0000);

    // R3 restart while running
    wr(1'b0, 32'h8000_0009);
    ticks(4);
    rd(1'b1, r); check("R3 mid count", r, 32'd5);
    wr(1'b0, 32'h8000_0002);
    rd(1'b1, r); check("R3 restart loads new preset", r, 32'd2);
    ticks(2);
    check("R3 no early expiry after restart", {31'b0, irq_o}, 32'h0);
    ticks(1);
    check("R3 expiry after restart", {31'b0, irq_o}, 32'h1);
    wr(1'b1, 32'h4000_0000);

    // R7 all-zero write stops a running periodic channel
    wr(1'b0, 32'hC000_0000);
    wr(1'b0, 32'h0000_0000);
    ticks(5);
    check("R7 stopped channel raises nothing", {31'b0, irq_o}, 32'h0);

    // R4 maximum preset
    wr(1'b0, 32'h9FFF_FFFF);
    rd(1'b1, r); check("R4 max preset loads", r, 32'h1FFF_FFFF);
    ticks(1);
    rd(1'b1, r); check("R4 max preset decrements", r, 32'h1FFF_FFFE);
    wr(1'b0, 32'h0);

    // R6 periodic 9999: expiry every 10000 ticks
    wr(1'b0, 32'hC000_270F);
    for (int p = 0; p < 2; p++) begin
      ticks(9999);
      check($sformatf("R6 period %0d no early irq", p), {31'b0, irq_o}, 32'h0);
      ticks(1);
      check($sformatf("R6 period %0d irq at 10000", p), {31'b0, irq_o}, 32'h1);
      wr(1'b1, 32'h4000_0000);
      // the clearing write cycle is not a tick; count stays at reload value
      rd(1'b1, r); check($sformatf("R6 period %0d reloaded", p), r, 32'd9999);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule